// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block sits on a simple register bus and fronts a small array of one-time-programmable fuse words. The array holds 16 banks of 8 words, each 32 bits wide, so every word has a 7-bit linear index equal to bank × 8 + word. Software never reads the fuses directly. It reads a shadow copy, and that copy changes only when software asks for a reload. A fuse bit can go from 0 to 1 but never back, so programming a word merges the new value into the stored word with a bitwise OR.

To program a word, software first checks that the busy flag is low and clears any stale error. It then writes the control register with the word index and a 16-bit unlock key, and finally writes the value to the data register. The write to the data register starts the program cycle, which keeps busy high for a fixed number of clock cycles. When the cycle completes, the key field clears itself, so every fuse write needs a new unlock. A reload request copies every fuse word into its shadow slot, one word after another, with busy held high throughout. Any request that arrives with the wrong key, or while busy is high, is refused: the error flag is set and the array is left unchanged.

Shadow words appear in the bus window from byte offset 0x400, 16 bytes apart. Every bank from bank 6 upward sits a further 0x100 bytes higher, which leaves an unmapped hole between bank 5 and bank 6.

Top module: `fuse_ctrl_top`

## Requirements
- R1: After reset, the control register at offset 0x000 reads 0x00000000 and every shadow word reads zero.
- R2: The control register at offset 0x000 has the following layout: word index in bits 6:0, busy in bit 8, error in bit 9, reload-in-progress in bit 10, unlock key in bits 31:16, and zero in all other bits. A write to it while idle loads the index and key fields, and the write cannot change bits 8 and 9.
- R3: A write to offset 0x008 clears the index bits, key bits and error bit (bit 9) that are set in the write data, and has no other effect. Reads of 0x008 return zero.
- R4: A write to the data register at offset 0x020, made while idle with the key field equal to 0x3E77, starts a program cycle. Busy is then high for exactly PROG_CYCLES cycles, and the written value is ORed into the fuse word selected by the index field.
- R5: A write to the data register made with any other key value, or while busy, sets error, does not raise busy and leaves the fuse array unchanged.
- R6: When a program cycle completes, the key field reads zero and the index field is kept. A later data write without a new unlock is refused as in R5.
- R7: A write to the control register with bit 10 set, made while idle, reloads every shadow word from its fuse word. Busy and bit 10 stay high for exactly 128 × LOAD_CYCLES cycles. The same request made while busy sets error instead.
- R8: Programming does not change any shadow word until a reload has completed.
- R9: The shadow of word index i is read at byte offset 0x400 + 16·i for i < 48, and at 0x400 + 16·i + 0x100 for i ≥ 48.
- R10: Reads of any offset that R2, R9 and the control-register mapping do not assign return zero. This covers the data register, the 0x700–0x7F0 gap, offsets that are not multiples of 16 inside the window, and offsets past the last shadow.
- R11: Writes to the control register made while busy leave the index and key fields unchanged.
- R12: Read data is registered: the value for an address presented before a rising edge appears on the read port after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the current bus address |
| bus_addr | input | 12 | Byte offset into the register space |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |

## Verification
Read data is due one rising edge after the address is presented, so the bench drives on falling edges and samples the port on the following falling edge. Status therefore lags the state by one cycle. Busy goes high at the edge where the data or reload write is taken, and that edge appears in the second read after the write. The program and reload windows are measured as the number of consecutive polled samples with busy set, and the bench compares that count with PROG_CYCLES and with 128 × LOAD_CYCLES, which does not depend on the fixed offset. The effect of a program on the array is judged only through shadow reads taken after a completed reload, and these are compared against a model that ORs each accepted value into its word.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    // Geometry
    localparam int N_BANKS  = 16;
    localparam int WPB      = 8;
    localparam int WORD_W   = 32;
    localparam int N_WORDS  = N_BANKS * WPB;
    localparam int IDX_W    = $clog2(N_WORDS);
    localparam int BUS_AW   = 12;
    localparam int KEY_W    = 16;

    localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h3E77;

    // Register offsets
    localparam logic [BUS_AW-1:0] OFF_CTRL = 12'h000;
    localparam logic [BUS_AW-1:0] OFF_CLR  = 12'h008;
    localparam logic [BUS_AW-1:0] OFF_DATA = 12'h020;
    localparam logic [BUS_AW-1:0] SHD_BASE = 12'h400;
    localparam int STRIDE_LG  = 4;
    localparam int GAP_BANK   = 6;
    localparam int GAP_BYTES  = 256;
    localparam int FIRST_GAP  = GAP_BANK * WPB;
    localparam int GAP_SLOTS  = GAP_BYTES / (1 << STRIDE_LG);

    // Control field positions
    localparam int B_BUSY   = 8;
    localparam int B_ERR    = 9;
    localparam int B_RELOAD = 10;
    localparam int B_KEY    = 16;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_PROG,
        SEQ_LOAD
    } seq_state_e;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] value;
    } prog_req_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } shd_sel_t;

    // Map a bus offset to a shadow slot, honouring the gap after bank 5.
    function automatic shd_sel_t shd_decode(input logic [BUS_AW-1:0] a);
        shd_sel_t         s;
        logic [BUS_AW-1:0] rel;
        int               slot;
        s    = '0;
        rel  = a - SHD_BASE;
        slot = int'(rel >> STRIDE_LG);
        if (a >= SHD_BASE && a[STRIDE_LG-1:0] == '0) begin
            if (slot < FIRST_GAP) begin
                s.hit = 1'b1;
                s.idx = IDX_W'(slot);
            end else if (slot >= FIRST_GAP + GAP_SLOTS && slot < N_WORDS + GAP_SLOTS) begin
                s.hit = 1'b1;
                s.idx = IDX_W'(slot - GAP_SLOTS);
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/fuse_array.sv
module fuse_array #(
    parameter int N = 128,
    parameter int W = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pgm_en,
    input  logic [AW-1:0] pgm_idx,
    input  logic [W-1:0]  pgm_val,
    input  logic [AW-1:0] rd_idx,
    output logic [W-1:0]  rd_val
);
    logic [W-1:0] mem [N];

    // Bits can only be set: programming merges with OR.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else if (pgm_en) begin
            mem[pgm_idx] <= mem[pgm_idx] | pgm_val;
        end
    end

    assign rd_val = mem[rd_idx];
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank #(
    parameter int N = 128,
    parameter int W = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [W-1:0]  wr_val,
    input  logic [AW-1:0] rd_idx,
    output logic [W-1:0]  rd_val
);
    logic [W-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_val;
        end
    end

    assign rd_val = mem[rd_idx];
endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
    import fuse_pkg::*;
#(
    parameter int N_WRD       = 128,
    parameter int PROG_CYCLES = 4,
    parameter int LOAD_CYCLES = 2,
    localparam int MAXC  = (PROG_CYCLES > LOAD_CYCLES) ? PROG_CYCLES : LOAD_CYCLES,
    localparam int CNT_W = $clog2(MAXC + 1),
    localparam int AW    = $clog2(N_WRD)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_prog,
    input  logic          start_load,
    output logic          busy,
    output logic          loading,
    output logic          prog_done,
    output logic          load_we,
    output logic [AW-1:0] load_idx
);
    localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] LOAD_LAST = CNT_W'(LOAD_CYCLES - 1);
    localparam logic [AW-1:0]    IDX_LAST  = AW'(N_WRD - 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [AW-1:0]    idx;

    assign busy      = (state != SEQ_IDLE);
    assign loading   = (state == SEQ_LOAD);
    assign prog_done = (state == SEQ_PROG) && (cnt == '0);
    assign load_we   = (state == SEQ_LOAD) && (cnt == '0);
    assign load_idx  = idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
            idx   <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (start_prog) begin
                        state <= SEQ_PROG;
                        cnt   <= PROG_LAST;
                    end else if (start_load) begin
                        state <= SEQ_LOAD;
                        cnt   <= LOAD_LAST;
                        idx   <= '0;
                    end
                end
                SEQ_PROG: begin
                    if (cnt == '0) state <= SEQ_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                SEQ_LOAD: begin
                    if (cnt == '0) begin
                        if (idx == IDX_LAST) begin
                            state <= SEQ_IDLE;
                        end else begin
                            idx <= idx + 1'b1;
                            cnt <= LOAD_LAST;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fuse_ctrl_top.sv
module fuse_ctrl_top
    import fuse_pkg::*;
#(
    parameter int PROG_CYCLES = 4,
    parameter int LOAD_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata
);
    logic [IDX_W-1:0]  addr_q;
    logic [KEY_W-1:0]  key_q;
    logic              err_q;
    prog_req_t         req_q;

    logic              busy, loading, prog_done, load_we;
    logic [IDX_W-1:0]  load_idx;
    logic [WORD_W-1:0] fuse_rd, shd_rd, ctrl_rd, rd_next;
    shd_sel_t          sel;

    logic wr_ctrl, wr_clr, wr_data, start_prog, start_load, err_set;

    assign wr_ctrl    = bus_we && (bus_addr == OFF_CTRL);
    assign wr_clr     = bus_we && (bus_addr == OFF_CLR);
    assign wr_data    = bus_we && (bus_addr == OFF_DATA);
    assign start_prog = wr_data && !busy && (key_q == UNLOCK_KEY);
    assign start_load = wr_ctrl && !busy && bus_wdata[B_RELOAD];
    assign err_set    = (wr_data && !start_prog) ||
                        (wr_ctrl && busy && bus_wdata[B_RELOAD]);

    fuse_seq #(
        .N_WRD      (N_WORDS),
        .PROG_CYCLES(PROG_CYCLES),
        .LOAD_CYCLES(LOAD_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_prog(start_prog),
        .start_load(start_load),
        .busy      (busy),
        .loading   (loading),
        .prog_done (prog_done),
        .load_we   (load_we),
        .load_idx  (load_idx)
    );

    fuse_array #(.N(N_WORDS), .W(WORD_W)) u_fuse (
        .clk    (clk),
        .rst    (rst),
        .pgm_en (prog_done),
        .pgm_idx(req_q.idx),
        .pgm_val(req_q.value),
        .rd_idx (load_idx),
        .rd_val (fuse_rd)
    );

    shadow_bank #(.N(N_WORDS), .W(WORD_W)) u_shadow (
        .clk   (clk),
        .rst   (rst),
        .wr_en (load_we),
        .wr_idx(load_idx),
        .wr_val(fuse_rd),
        .rd_idx(sel.idx),
        .rd_val(shd_rd)
    );

    // Control register view
    always_comb begin
        ctrl_rd                   = '0;
        ctrl_rd[IDX_W-1:0]        = addr_q;
        ctrl_rd[B_BUSY]           = busy;
        ctrl_rd[B_ERR]            = err_q;
        ctrl_rd[B_RELOAD]         = loading;
        ctrl_rd[B_KEY +: KEY_W]   = key_q;
    end

    always_comb begin
        sel = shd_decode(bus_addr);
        if (bus_addr == OFF_CTRL) rd_next = ctrl_rd;
        else if (sel.hit)         rd_next = shd_rd;
        else                      rd_next = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            key_q     <= '0;
            err_q     <= 1'b0;
            req_q     <= '0;
            bus_rdata <= '0;
        end else begin
            bus_rdata <= rd_next;
            if (wr_ctrl && !busy) begin
                addr_q <= bus_wdata[IDX_W-1:0];
                key_q  <= bus_wdata[B_KEY +: KEY_W];
            end
            if (wr_clr) begin
                addr_q <= addr_q & ~bus_wdata[IDX_W-1:0];
                key_q  <= key_q  & ~bus_wdata[B_KEY +: KEY_W];
            end
            if (prog_done) key_q <= '0;
            if (wr_clr && bus_wdata[B_ERR]) err_q <= 1'b0;
            if (err_set) err_q <= 1'b1;
            if (start_prog) begin
                req_q.idx   <= addr_q;
                req_q.value <= bus_wdata;
            end
        end
    end
endmodule

// File: rtl/fuse_ctrl_chk.sv
module fuse_ctrl_chk
    import fuse_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              we,
    input logic [BUS_AW-1:0] addr,
    input logic              wd_err,
    input logic              wd_reload,
    input logic              busy,
    input logic              err,
    input logic [KEY_W-1:0]  key,
    input logic              prog_done
);
    logic hit_ctrl, hit_clr, hit_data;
    assign hit_ctrl = we && (addr == OFF_CTRL);
    assign hit_clr  = we && (addr == OFF_CLR);
    assign hit_data = we && (addr == OFF_DATA);

    // R4: unlocked data write while idle starts busy
    a_r4_prog_starts: assert property (@(posedge clk) disable iff (rst)
        (hit_data && !busy && key == UNLOCK_KEY) |=> busy);

    // R5: refused data write flags error
    a_r5_refused_sets_err: assert property (@(posedge clk) disable iff (rst)
        (hit_data && (busy || key != UNLOCK_KEY)) |=> err);

    // R3: error only drops through the clear alias
    a_r3_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (err && !(hit_clr && wd_err)) |=> err);

    // R6: key wiped once programming finishes
    a_r6_key_wiped: assert property (@(posedge clk) disable iff (rst)
        prog_done |=> (key == '0));

    // R7: reload request while busy flags error
    a_r7_reload_busy_err: assert property (@(posedge clk) disable iff (rst)
        (hit_ctrl && busy && wd_reload) |=> err);

    // R4/R7: busy only ever begins because of a bus write
    a_r4_busy_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(we));
endmodule

bind fuse_ctrl_top fuse_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .we       (bus_we),
    .addr     (bus_addr),
    .wd_err   (bus_wdata[fuse_pkg::B_ERR]),
    .wd_reload(bus_wdata[fuse_pkg::B_RELOAD]),
    .busy     (busy),
    .err      (err_q),
    .key      (key_q),
    .prog_done(prog_done)
);

// File: tb/fuse_ctrl_top_bench.sv
`timescale 1ns/1ps
module fuse_ctrl_top_bench;
    localparam int PC  = 6;
    localparam int LC  = 2;
    localparam int NW  = 128;
    localparam logic [15:0] KEY = 16'h3E77;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    logic [31:0] fuse_m [NW];
    logic [31:0] shd_m  [NW];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fuse_ctrl_top #(.PROG_CYCLES(PC), .LOAD_CYCLES(LC)) u_fuse_ctrl_top (
        .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata)
    );

    function automatic logic [11:0] shd_off(int idx);
        return 12'(32'h400 + idx * 16 + ((idx >= 48) ? 256 : 0));
    endfunction

    function automatic logic [31:0] ctrl_exp(logic [15:0] k, bit rl, bit er, bit bz, logic [6:0] a);
        return {k, 5'b0, rl, er, bz, 1'b0, a};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v);
        addr = a; we = 1'b0;
        @(negedge clk);
        v = rdata;
    endtask

    task automatic wait_idle(output int nb, output int nr);
        bit seen = 1'b0;
        nb = 0; nr = 0;
        addr = 12'h000; we = 1'b0;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (rdata[8]) begin
                nb++; seen = 1'b1;
                if (rdata[10]) nr++;
            end else if (seen || k >= 3) begin
                break;
            end
        end
    endtask

    task automatic reload();
        int nb, nr;
        wr(12'h000, 32'h0000_0400);
        wait_idle(nb, nr);
        check("R7 reload busy length", nb, NW * LC);
        check("R7 reload bit during reload", nr, NW * LC);
        for (int i = 0; i < NW; i++) shd_m[i] = fuse_m[i];
    endtask

    task automatic prog(int idx, logic [31:0] val, bit good);
        int nb, nr;
        logic [31:0] v;
        logic [15:0] k = good ? KEY : ~KEY;
        wr(12'h000, {k, 9'b0, 7'(idx)});
        wr(12'h020, val);
        wait_idle(nb, nr);
        if (good) begin
            check("R4 program busy length", nb, PC);
            fuse_m[idx] = fuse_m[idx] | val;
        end else begin
            check("R5 refused write raises no busy", nb, 0);
        end
        rd(12'h000, v);
        check(good ? "R6 key cleared index kept" : "R5 error set on wrong key",
              v, ctrl_exp(good ? 16'h0 : k, 1'b0, !good, 1'b0, 7'(idx)));
        wr(12'h008, 32'hFFFF_FFFF);
    endtask

    task automatic cmp_shadow(int idx, string req);
        logic [31:0] v;
        rd(shd_off(idx), v);
        check(req, v, shd_m[idx]);
    endtask

    initial begin
        logic [31:0] v;
        int nb, nr;
        for (int i = 0; i < NW; i++) begin fuse_m[i] = '0; shd_m[i] = '0; end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(12'h000, v); check("R1 control after reset", v, 32'h0);
        cmp_shadow(0, "R1 shadow 0 after reset");
        cmp_shadow(127, "R1 shadow 127 after reset");

        // R2 layout; bits 8/9 not writable
        wr(12'h000, 32'h1234_0305);
        rd(12'h000, v); check("R2 control readback", v, ctrl_exp(16'h1234, 0, 0, 0, 7'h05));

        // R3 clear alias hits only the selected bits
        wr(12'h008, 32'hFFFF_0000);
        rd(12'h000, v); check("R3 clear key keeps index", v, ctrl_exp(16'h0, 0, 0, 0, 7'h05));
        rd(12'h008, v); check("R3 clear alias reads zero", v, 32'h0);

        // R5 wrong key
        wr(12'h020, 32'hDEAD_BEEF);
        rd(12'h000, v); check("R5 wrong key error", v, ctrl_exp(16'h0, 0, 1, 0, 7'h05));
        wr(12'h008, 32'h0000_0200);
        rd(12'h000, v); check("R3 error cleared", v, ctrl_exp(16'h0, 0, 0, 0, 7'h05));

        // R4/R8 directed program, then R7 reload
        prog(19, 32'hA5A5_0F0F, 1'b1);
        cmp_shadow(19, "R8 shadow unchanged before reload");
        reload();
        cmp_shadow(19, "R7 shadow after reload");
        prog(19, 32'h0000_F0F0, 1'b1);
        reload();
        check("R4 OR merge model", fuse_m[19], 32'hA5A5_FFFF);
        cmp_shadow(19, "R4 OR merge into fuse word");

        // Collisions while busy
        wr(12'h000, {KEY, 9'b0, 7'd10});
        wr(12'h020, 32'h0000_0001);
        wr(12'h020, 32'h0000_FFFF);              // R5 while busy
        wr(12'h000, {16'h1111, 9'b0, 7'h7F});    // R11 ignored
        wr(12'h000, 32'h0000_0400);              // R7 reload while busy
        wait_idle(nb, nr);
        fuse_m[10] = fuse_m[10] | 32'h1;
        rd(12'h000, v); check("R11 busy write ignored, R5/R7 error", v, ctrl_exp(16'h0, 0, 1, 0, 7'd10));
        wr(12'h008, 32'h0000_0200);

        // R6 fresh unlock needed
        wr(12'h020, 32'h0000_0080);
        wait_idle(nb, nr);
        check("R6 no busy without fresh unlock", nb, 0);
        rd(12'h000, v); check("R6 error without fresh unlock", v, ctrl_exp(16'h0, 0, 1, 0, 7'd10));
        wr(12'h008, 32'hFFFF_FFFF);

        // R9 gap boundary words
        prog(47, 32'h4747_0001, 1'b1);
        prog(48, 32'h4848_0002, 1'b1);
        prog(127, 32'h7F7F_0003, 1'b1);
        reload();
        cmp_shadow(10, "R5 only the accepted value landed");
        rd(12'h6F0, v); check("R9 bank5 word7", v, 32'h4747_0001);
        rd(12'h800, v); check("R9 bank6 word0", v, 32'h4848_0002);
        rd(12'hCF0, v); check("R9 bank15 word7", v, 32'h7F7F_0003);

        // R10 unmapped reads
        rd(12'h700, v); check("R10 gap start", v, 32'h0);
        rd(12'h7F0, v); check("R10 gap end", v, 32'h0);
        rd(12'h804, v); check("R10 misaligned", v, 32'h0);
        rd(12'h020, v); check("R10 data register read", v, 32'h0);
        rd(12'h010, v); check("R10 unassigned low", v, 32'h0);
        rd(12'hD00, v); check("R10 past last shadow", v, 32'h0);

        // R12 back-to-back reads
        addr = 12'h800; @(negedge clk);
        check("R12 first registered read", rdata, 32'h4848_0002);
        addr = 12'h6F0; @(negedge clk);
        check("R12 second registered read", rdata, 32'h4747_0001);

        // Random programs with periodic reloads
        for (int it = 0; it < 24; it++) begin
            int idx = int'($urandom_range(0, NW - 1));
            logic [31:0] val = $urandom;
            bit good = ($urandom_range(0, 3) != 0);
            prog(idx, val, good);
            if (it % 6 == 5) begin
                reload();
                for (int j = 0; j < 6; j++) cmp_shadow(int'($urandom_range(0, NW - 1)), "R9 random shadow");
                cmp_shadow(idx, "R4 random program result");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule